// File: doc/BRIEF.md
# Block-Mapped Flash Address Translator

This block turns a bus address into a flash byte address. It uses a table of programmable mapping entries. Each entry ties a block-aligned region of the bus address space to a run of consecutive flash blocks. A block is 16 KiB. The region spans a power-of-two number of blocks, and the alignment of the region's base limits how large that number can be. Each entry has two gates, one for CPU accesses and one for DMA accesses. An entry may also be marked as an initialization-vector source. A hit on such an entry tells the requester to take the 16-byte vector from a local register, and no flash access takes place.

Programming an entry takes two steps. First, software loads a staging register with the block-count exponent and the three flags. Second, software writes the base block and the flash start block to an indexed entry slot. That write commits the slot, combining the two fields with whatever the staging register holds at that moment. A lookup is started with a one-cycle request that carries the address and the access type. The block then checks the entries in index order, one entry per clock, and stops at the first entry that matches. A one-cycle done pulse presents the result: hit or miss, the vector marker and the flash address.

Top module: `xlat_map_top`

## Requirements
- R1: After reset, no entry is enabled. Every lookup misses, and busy, done, hit, the vector marker and the flash address are all 0.
- R2: A slot write commits the base block and flash start block from the ports, together with the staging register as it stands at that moment. Changing the staging register afterwards has no effect on entries already committed.
- R3: An entry covers 2^k blocks starting at its base block. Here k = min(number of trailing zeros of the 16-bit base block, staged exponent). A base block of 0 counts as 16 trailing zeros.
- R4: On a hit, the flash address is the flash start block plus (address bits [29:14] minus the base block), placed above address bits [13:0]. It is 30 bits wide.
- R5: With the access type low (CPU), an entry can match only when its CPU enable is set.
- R6: With the access type high (DMA), an entry can match only when its DMA enable is set.
- R7: A hit on an entry with the vector flag set reports hit=1, marker=1 and a flash address of 0.
- R8: Entries are checked from index 0 upward, one per cycle, and the lowest matching index wins. Take the edge that samples the request as edge t. A hit on index j raises done after edge t+1+j. A miss raises done after edge t+N, where N is the entry count.
- R9: A miss reports hit=0, marker=0 and a flash address of 0.
- R10: Address bits above bit 29 have no effect on the result.
- R11: A request raised while a lookup is in progress is ignored.
- R12: Done lasts exactly one cycle, and busy is low while done is high. The result outputs hold their values until the next done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| stageWr | input | 1 | Load the staging register |
| stageLog2Cnt | input | 4 | Staged block-count exponent |
| stageCpuEn | input | 1 | Staged CPU enable |
| stageDmaEn | input | 1 | Staged DMA enable |
| stageIvSrc | input | 1 | Staged vector-source flag |
| entryWr | input | 1 | Commit one entry slot |
| entryIdx | input | clog2(NUM_ENTRIES) | Slot to commit |
| entryBaseBlk | input | 16 | Bus base block (address bits [29:14]) |
| entryFlashBlk | input | 16 | Flash start block |
| lookupReq | input | 1 | Start a lookup |
| lookupAddr | input | 32 | Bus address to translate |
| lookupIsDma | input | 1 | 1 = DMA access, 0 = CPU access |
| lookupBusy | output | 1 | Scan in progress |
| lookupDone | output | 1 | One-cycle result strobe |
| lookupHit | output | 1 | An entry matched |
| lookupIv | output | 1 | The matching entry is a vector source |
| flashAddr | output | 30 | Translated flash byte address |

## Verification
The bench uses an eight-entry table. Its entries have aligned bases, bases whose alignment clamps the count, an entry that overlaps an earlier one, a base of zero, a vector-source entry and a disabled slot. Every block from 0 to 0x2F is looked up as both a CPU access and a DMA access, and the upper address bits change from lookup to lookup. This sweep separates the count clamp from the plain exponent, exposes enable gating by access type, and checks through done latency which of two overlapping entries wins. Edge blocks around the vector entry and around the large region at 0x4000 test the inclusive and exclusive ends of a range. Two further patterns are covered: a second request raised while a scan is running, and staging changes made after a commit.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef struct packed {
    logic start;
    logic advance;
    logic finish;
  } scanCtl_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_SCAN = 1'b1} scanState_t;
endpackage

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import xlat_pkg::*;
#(
  parameter int NUM_ENTRIES = 192,
  parameter int BLK_W       = 16,
  parameter int OFF_W       = 14,
  parameter int LOG_W       = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         stageWr,
  input  logic [LOG_W-1:0]             stageLog2Cnt,
  input  logic                         stageCpuEn,
  input  logic                         stageDmaEn,
  input  logic                         stageIvSrc,
  input  logic                         entryWr,
  input  logic [$clog2(NUM_ENTRIES)-1:0] entryIdx,
  input  logic [BLK_W-1:0]             entryBaseBlk,
  input  logic [BLK_W-1:0]             entryFlashBlk,
  input  logic [BLK_W+OFF_W-1:0]       reqAddr,
  input  logic                         reqIsDma,
  input  scanCtl_t                     ctl,
  output logic                         entryMatch,
  output logic                         lastEntry,
  output logic                         hitQ,
  output logic                         ivQ,
  output logic [BLK_W+OFF_W-1:0]       flashQ
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam int TZ_W  = $clog2(BLK_W + 1);

  // staging register
  logic [LOG_W-1:0] stLog;
  logic             stCpu, stDma, stIv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stLog <= '0; stCpu <= 1'b0; stDma <= 1'b0; stIv <= 1'b0;
    end else if (stageWr) begin
      stLog <= stageLog2Cnt; stCpu <= stageCpuEn;
      stDma <= stageDmaEn;   stIv  <= stageIvSrc;
    end
  end

  function automatic logic [TZ_W-1:0] trailZeros(input logic [BLK_W-1:0] v);
    logic [TZ_W-1:0] n;
    n = TZ_W'(BLK_W);
    for (int i = BLK_W - 1; i >= 0; i--) if (v[i]) n = TZ_W'(i);
    return n;
  endfunction

  logic [TZ_W-1:0]  newTz;
  logic [LOG_W-1:0] newEffLog;
  logic             slotOk;

  always_comb begin
    newTz     = trailZeros(entryBaseBlk);
    newEffLog = (newTz < TZ_W'(stLog)) ? LOG_W'(newTz) : stLog;
    slotOk    = (32'(entryIdx) < NUM_ENTRIES);
  end

  // entry storage: enables reset, address fields not
  logic [NUM_ENTRIES-1:0] cpuEnV, dmaEnV, ivV;
  logic [BLK_W-1:0]       baseMem  [NUM_ENTRIES];
  logic [BLK_W-1:0]       blkMem   [NUM_ENTRIES];
  logic [LOG_W-1:0]       effLogMem[NUM_ENTRIES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuEnV <= '0; dmaEnV <= '0; ivV <= '0;
    end else if (entryWr && slotOk) begin
      cpuEnV[entryIdx] <= stCpu;
      dmaEnV[entryIdx] <= stDma;
      ivV[entryIdx]    <= stIv;
    end
  end

  always_ff @(posedge clk) begin
    if (entryWr && slotOk) begin
      baseMem[entryIdx]   <= entryBaseBlk;
      blkMem[entryIdx]    <= entryFlashBlk;
      effLogMem[entryIdx] <= newEffLog;
    end
  end

  // latched request and scan pointer
  logic [IDX_W-1:0] scanIdx;
  logic [BLK_W-1:0] reqBlkQ;
  logic [OFF_W-1:0] reqOffQ;
  logic             reqDmaQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanIdx <= '0; reqBlkQ <= '0; reqOffQ <= '0; reqDmaQ <= 1'b0;
    end else if (ctl.start) begin
      scanIdx <= '0;
      reqBlkQ <= reqAddr[BLK_W+OFF_W-1:OFF_W];
      reqOffQ <= reqAddr[OFF_W-1:0];
      reqDmaQ <= reqIsDma;
    end else if (ctl.advance) begin
      scanIdx <= scanIdx + 1'b1;
    end
  end

  logic [BLK_W-1:0] curDiff;
  logic             inRange, typeOk;

  always_comb begin
    curDiff    = reqBlkQ - baseMem[scanIdx];
    inRange    = (reqBlkQ >= baseMem[scanIdx]) && ((curDiff >> effLogMem[scanIdx]) == '0);
    typeOk     = reqDmaQ ? dmaEnV[scanIdx] : cpuEnV[scanIdx];
    entryMatch = inRange && typeOk;
    lastEntry  = (32'(scanIdx) == NUM_ENTRIES - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitQ <= 1'b0; ivQ <= 1'b0; flashQ <= '0;
    end else if (ctl.finish) begin
      hitQ   <= entryMatch;
      ivQ    <= entryMatch && ivV[scanIdx];
      flashQ <= (entryMatch && !ivV[scanIdx]) ?
                {blkMem[scanIdx] + curDiff, reqOffQ} : '0;
    end
  end

  assert_idx_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    32'(scanIdx) < NUM_ENTRIES);
  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> $stable(reqBlkQ) && $stable(reqDmaQ));
  assert_miss_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finish && !entryMatch |=> !hitQ && !ivQ && flashQ == '0);
  assert_iv_no_flash_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finish && entryMatch && ivV[scanIdx] |=> ivQ && flashQ == '0);
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     lookupReq,
  input  logic     entryMatch,
  input  logic     lastEntry,
  output scanCtl_t ctl,
  output logic     busy,
  output logic     done
);
  scanState_t state;

  always_comb begin
    ctl = '0;
    if (state == ST_IDLE) ctl.start = lookupReq;
    else if (entryMatch || lastEntry) ctl.finish = 1'b1;
    else ctl.advance = 1'b1;
    busy = (state == ST_SCAN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; done <= 1'b0;
    end else begin
      done <= ctl.finish;
      if (ctl.start) state <= ST_SCAN;
      else if (ctl.finish) state <= ST_IDLE;
    end
  end

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: rtl/xlat_map_top.sv
module xlat_map_top
  import xlat_pkg::*;
#(
  parameter int NUM_ENTRIES = 192,
  parameter int ADDR_W      = 32,
  parameter int BLK_W       = 16,
  parameter int OFF_W       = 14,
  parameter int LOG_W       = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           stageWr,
  input  logic [LOG_W-1:0]               stageLog2Cnt,
  input  logic                           stageCpuEn,
  input  logic                           stageDmaEn,
  input  logic                           stageIvSrc,
  input  logic                           entryWr,
  input  logic [$clog2(NUM_ENTRIES)-1:0] entryIdx,
  input  logic [BLK_W-1:0]               entryBaseBlk,
  input  logic [BLK_W-1:0]               entryFlashBlk,
  input  logic                           lookupReq,
  input  logic [ADDR_W-1:0]              lookupAddr,
  input  logic                           lookupIsDma,
  output logic                           lookupBusy,
  output logic                           lookupDone,
  output logic                           lookupHit,
  output logic                           lookupIv,
  output logic [BLK_W+OFF_W-1:0]         flashAddr
);
  localparam int MAP_W = BLK_W + OFF_W;

  scanCtl_t ctl;
  logic     entryMatch, lastEntry;
  logic     unusedAddrBits;

  assign unusedAddrBits = ^lookupAddr[ADDR_W-1:MAP_W];

  xlat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lookupReq(lookupReq),
    .entryMatch(entryMatch), .lastEntry(lastEntry),
    .ctl(ctl), .busy(lookupBusy), .done(lookupDone)
  );

  xlat_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .BLK_W(BLK_W), .OFF_W(OFF_W), .LOG_W(LOG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .stageWr(stageWr), .stageLog2Cnt(stageLog2Cnt), .stageCpuEn(stageCpuEn),
    .stageDmaEn(stageDmaEn), .stageIvSrc(stageIvSrc),
    .entryWr(entryWr), .entryIdx(entryIdx),
    .entryBaseBlk(entryBaseBlk), .entryFlashBlk(entryFlashBlk),
    .reqAddr(lookupAddr[MAP_W-1:0]), .reqIsDma(lookupIsDma),
    .ctl(ctl), .entryMatch(entryMatch), .lastEntry(lastEntry),
    .hitQ(lookupHit), .ivQ(lookupIv), .flashQ(flashAddr)
  );

  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    lookupDone |-> $past(lookupBusy));
endmodule

// File: tb/xlat_map_top_tb.sv
module xlat_map_top_tb;
  localparam int N = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic stageWr = 0, stageCpuEn = 0, stageDmaEn = 0, stageIvSrc = 0;
  logic [3:0] stageLog2Cnt = 0;
  logic entryWr = 0;
  logic [2:0] entryIdx = 0;
  logic [15:0] entryBaseBlk = 0, entryFlashBlk = 0;
  logic lookupReq = 0, lookupIsDma = 0;
  logic [31:0] lookupAddr = 0;
  logic lookupBusy, lookupDone, lookupHit, lookupIv;
  logic [29:0] flashAddr;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  xlat_map_top #(.NUM_ENTRIES(N)) u_dut (.*);

  // bench model
  logic [15:0] mBase[N], mBlk[N];
  int          mLog[N];
  bit          mCpu[N], mDma[N], mIv[N];
  int          sLog;
  bit          sCpu, sDma, sIv;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int tzb(input logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return i;
    return 16;
  endfunction

  task automatic stage(input int lg, input bit c, input bit d, input bit iv);
    @(negedge clk);
    stageWr = 1; stageLog2Cnt = 4'(lg); stageCpuEn = c; stageDmaEn = d; stageIvSrc = iv;
    @(negedge clk);
    stageWr = 0;
    sLog = lg; sCpu = c; sDma = d; sIv = iv;
  endtask

  task automatic commit(input int idx, input logic [15:0] base, input logic [15:0] blk);
    @(negedge clk);
    entryWr = 1; entryIdx = 3'(idx); entryBaseBlk = base; entryFlashBlk = blk;
    @(negedge clk);
    entryWr = 0;
    mBase[idx] = base; mBlk[idx] = blk;
    mLog[idx] = (tzb(base) < sLog) ? tzb(base) : sLog;
    mCpu[idx] = sCpu; mDma[idx] = sDma; mIv[idx] = sIv;
  endtask

  task automatic lookup(input logic [31:0] a, input bit dma, input bit interfere, input string tag);
    int eIdx, lat, cnt;
    logic [15:0] b;
    logic [29:0] eFlash;
    bit eHit, eIv;
    b = a[29:14];
    eIdx = -1;
    for (int i = 0; i < N; i++)
      if (eIdx < 0 && (dma ? mDma[i] : mCpu[i]) && b >= mBase[i] &&
          int'(b - mBase[i]) < (1 << mLog[i])) eIdx = i;
    eHit = (eIdx >= 0);
    eIv = eHit && mIv[eIdx];
    eFlash = (eHit && !eIv) ? {mBlk[eIdx] + (b - mBase[eIdx]), a[13:0]} : 30'd0;
    lat = eHit ? eIdx + 1 : N;
    @(negedge clk);
    lookupReq = 1; lookupAddr = a; lookupIsDma = dma;
    @(posedge clk);
    @(negedge clk);
    lookupReq = 0;
    cnt = 0;
    while (cnt < N + 4) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      lookupReq = 0;
      if (lookupDone) break;
      if (interfere && cnt == 1) begin
        lookupReq = 1; lookupAddr = a ^ 32'h0000_4000; lookupIsDma = ~dma;
      end
    end
    check(cnt == lat, {"R8 latency ", tag}, cnt, lat);
    check(lookupHit == eHit, {"hit ", tag}, lookupHit, eHit);
    check(lookupIv == eIv, {"R7 iv ", tag}, lookupIv, eIv);
    check(flashAddr == eFlash, {"R4 flash ", tag}, flashAddr, eFlash);
    check(!lookupBusy, "R12 busy low at done", lookupBusy, 0);
    @(negedge clk);
    check(!lookupDone && lookupHit == eHit && flashAddr == eFlash,
          "R12 single pulse and hold", {lookupDone, flashAddr}, {1'b0, eFlash});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mBase[i] = 0; mBlk[i] = 0; mLog[i] = 0; mCpu[i] = 0; mDma[i] = 0; mIv[i] = 0;
    end
    sLog = 0; sCpu = 0; sDma = 0; sIv = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!lookupBusy && !lookupDone && !lookupHit && !lookupIv && flashAddr == 0,
          "R1 reset outputs", {lookupBusy, lookupDone, lookupHit, lookupIv}, 0);
    lookup(32'h0000_0000, 0, 0, "R1 empty cpu");
    lookup(32'h1234_5678, 1, 0, "R1 R9 empty dma");

    stage(2, 1, 1, 0);  commit(0, 16'h0010, 16'h0100); // aligned, 4 blocks
    stage(3, 1, 0, 0);  commit(1, 16'h0014, 16'h0200); // clamped to 4 blocks, R3
    stage(0, 0, 1, 0);  commit(2, 16'h0018, 16'h0300); // single block, DMA only
    stage(2, 1, 1, 1);  commit(3, 16'h3FFC, 16'h0000); // vector source
    stage(15, 1, 1, 0); commit(4, 16'h4000, 16'h1000); // clamped to 2^14
    stage(0, 1, 1, 0);  commit(5, 16'h0012, 16'h0500); // shadowed by entry 0
    stage(4, 0, 1, 0);  commit(6, 16'h0000, 16'hF000); // zero base, DMA only
    stage(3, 0, 0, 0);  commit(7, 16'h0020, 16'h0700); // disabled
    stage(3, 1, 1, 1);  // staging change after commit, R2

    lookup({2'b00, 16'h0020, 14'h0011}, 0, 0, "R2 staged change ignored");
    lookup({2'b00, 16'h0017, 14'h0001}, 0, 0, "R3 clamped top block hits");
    lookup({2'b00, 16'h0017, 14'h0001}, 1, 0, "R5 R6 cpu-only entry under dma");
    lookup({2'b00, 16'h0018, 14'h0002}, 0, 0, "R6 dma-only entry under cpu");
    lookup({2'b00, 16'h0019, 14'h0002}, 1, 0, "R3 one-block entry end");
    lookup({2'b11, 16'h0012, 14'h3FFF}, 1, 0, "R10 high bits set");
    lookup({2'b00, 16'h0012, 14'h3FFF}, 1, 0, "R10 high bits clear");
    lookup({2'b00, 16'h0016, 14'h0ABC}, 0, 1, "R11 request during scan");

    for (int b = 0; b < 16'h30; b++)
      for (int d = 0; d < 2; d++)
        lookup({2'(b), 16'(b), 14'((b * 32'h1235) & 32'h3FFF)}, d[0], 0, "R3 R4 R5 R6 sweep");

    foreach (mBase[i]) begin end
    lookup({2'b01, 16'h3FFB, 14'h0}, 0, 0, "R9 below vector entry");
    lookup({2'b00, 16'h3FFC, 14'h0123}, 1, 0, "R7 vector first block");
    lookup({2'b10, 16'h3FFF, 14'h3FFF}, 0, 0, "R7 vector last block");
    lookup({2'b00, 16'h4000, 14'h0001}, 1, 0, "R3 big region start");
    lookup({2'b00, 16'h5A5A, 14'h1111}, 0, 0, "R4 big region middle");
    lookup({2'b00, 16'h7FFF, 14'h3FFF}, 1, 0, "R3 big region end");
    lookup({2'b00, 16'h8000, 14'h0000}, 0, 0, "R3 R9 past big region");
    lookup({2'b11, 16'hFFFF, 14'h3FFF}, 1, 0, "R9 top of space");

    commit(7, 16'h0020, 16'h0700);  // now uses all-enabled staging, R2
    lookup({2'b00, 16'h0021, 14'h0042}, 0, 0, "R2 recommit picks staging");
    lookup({2'b00, 16'h0021, 14'h0042}, 1, 0, "R2 R7 recommit vector flag");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule